// File: doc/BRIEF.md
# LIN Slave Sync-Field Baud Measurement

This block is the automatic baud-rate unit for the slave side of a LIN-capable UART receiver. A separate break detector announces the start of a frame with a one-cycle strobe. The block then watches the receive line through the sync field that follows. It counts system clocks across exactly eight bit periods of that field. It converts the count into an integer baud divisor and a fraction in eighths, in the form the receiver's bit-rate generator uses at sixteen-times oversampling.

The sync byte itself arrives from the receiver datapath as a byte with a valid strobe. The block loads the new divisor only when that byte is the expected sync pattern and the measurement is sound. It then reports the slave as synchronized. Any other outcome raises a sticky error flag, and the divisor is left alone. After an error the block disregards further bytes until the next break. The measurement works only if the slave's starting rate is close enough to the master's for the break to be recognised at all, which needs a mismatch under 15 percent.

Top module: `lin_autobaud`

## Requirements
- R1: The receive line passes through a two-flop synchronizer. The count is the number of clocks between the first falling edge after an armed break (the start bit) and the fourth falling edge after it (the start of data bit 7). The second and third falls are not end points. For a sync field with a bit period of P clocks, the count is 8·P.
- R2: `divInt` equals the count shifted right by 7. `divFrac` equals count bits [6:4], which is the fraction in eighths. For a bit period P, this gives divInt = P>>4 and divFrac = (P>>1) & 7.
- R3: Falling edges on the receive line before any break strobe start no measurement, and they never lead to a load.
- R4: Suppose a byte-valid strobe arrives after a complete measurement and the byte equals 0x55. Then `divLoad` is high for exactly the one cycle after that strobe, and `divInt`/`divFrac` take the new value in that same cycle.
- R5: `synced` rises together with `divLoad`. A break strobe drives it low in the following cycle.
- R6: Suppose the sync byte differs from 0x55. Then `syncErr` rises in the cycle after the byte strobe, nothing is loaded, and later bytes are ignored until the next break: they cause no load and leave `synced` low.
- R7: A byte-valid strobe that arrives before the fourth falling edge is a sync error, and nothing is loaded.
- R8: The counter stops at its all-ones value. A measurement that saturates, or one with a zero count, is a sync error and is never loaded.
- R9: `syncErr` stays high until an `errClear` pulse. If a new error and `errClear` fall in the same cycle, the error wins.
- R10: A break strobe during a measurement discards that measurement and re-arms the block. A break strobe in the same cycle as the sync byte takes priority, so no load happens.
- R11: After reset `divInt`, `divFrac`, `divLoad`, `synced` and `syncErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Receive line, idle high, not yet synchronized |
| breakSeen | input | 1 | One-cycle strobe: break character detected |
| rxByte | input | 8 | Byte delivered by the receiver datapath |
| rxByteValid | input | 1 | One-cycle strobe qualifying `rxByte` |
| errClear | input | 1 | Write-one-to-clear pulse for `syncErr` |
| divInt | output | INT_W | Integer baud divisor |
| divFrac | output | FRAC_W | Fractional baud divisor in eighths |
| divLoad | output | 1 | One-cycle strobe: new divisor committed |
| synced | output | 1 | Slave synchronized to the master |
| syncErr | output | 1 | Sticky sync-field error |

## Verification
Two pairs of events can land in the same clock. The first pair is a freshly detected sync error and an `errClear` pulse. The bench raises the byte strobe carrying a wrong byte on the same cycle as `errClear`, and it expects the flag to end up set. The second pair is a break strobe and the sync byte strobe. The bench drives both on one cycle after a clean measurement, and it expects no load pulse and `synced` low. A sweep over many bit periods compares the divisor with 8·P scaled by 128, which is computed in the bench.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;

  // Expected sync byte and the number of falling edges from the start bit
  // to the start of data bit 7 for that byte (bits sent LSB first).
  localparam logic [7:0] SYNC_PATTERN = 8'h55;
  localparam int         SYNC_FALLS   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_COUNT,
    ST_CHECK,
    ST_FAULT
  } abState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic divLoad;
  } abCmd_t;

endpackage

// File: rtl/lab_meas.sv
module lab_meas
  import lin_ab_pkg::*;
#(
  parameter int INT_W    = 13,
  parameter int FRAC_W   = 3,
  parameter int BIT_LOG2 = 3,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  abCmd_t            cmd,
  output logic              fallDet,
  output logic              cntSat,
  output logic              cntZero,
  output logic [INT_W-1:0]  divInt,
  output logic [FRAC_W-1:0] divFrac
);

  localparam int SHIFT = BIT_LOG2 + OVS_LOG2;
  localparam int CNT_W = INT_W + SHIFT;

  logic rxMeta, rxSync, rxPrev;
  logic [CNT_W-1:0] cnt;

  // Two-flop synchronizer plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  assign fallDet = rxPrev & ~rxSync;

  // Saturating measurement counter.
  assign cntSat  = &cnt;
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (cmd.cntClear)         cnt <= '0;
    else if (cmd.cntRun && !cntSat) cnt <= cnt + 1'b1;
  end

  // Divisor register: count / 2^BIT_LOG2 / 2^OVS_LOG2 as a right shift.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divInt  <= '0;
      divFrac <= '0;
    end else if (cmd.divLoad) begin
      divInt  <= cnt[CNT_W-1:SHIFT];
      divFrac <= cnt[SHIFT-1 -: FRAC_W];
    end
  end

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cntClear |=> cntZero);

  a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.cntRun && !cmd.cntClear && cntSat) |=> cntSat);

  a_r2_div_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.divLoad |=> ($stable(divInt) && $stable(divFrac)));

endmodule

// File: rtl/lab_ctrl.sv
module lab_ctrl
  import lin_ab_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       breakSeen,
  input  logic [7:0] rxByte,
  input  logic       rxByteValid,
  input  logic       errClear,
  input  logic       fallDet,
  input  logic       cntSat,
  input  logic       cntZero,
  output abCmd_t     cmd,
  output logic       divLoad,
  output logic       synced,
  output logic       syncErr
);

  localparam int FALLS_W = (SYNC_FALLS > 1) ? $clog2(SYNC_FALLS) : 1;
  localparam logic [FALLS_W-1:0] LAST_FALL = FALLS_W'(SYNC_FALLS - 1);

  abState_t state, stateNxt;
  logic [FALLS_W-1:0] fallIdx, fallIdxNxt;
  logic measGood, errSet;

  assign measGood = (rxByte == SYNC_PATTERN) && !cntSat && !cntZero;

  always_comb begin
    stateNxt   = state;
    fallIdxNxt = fallIdx;
    errSet     = 1'b0;
    cmd        = '0;
    if (breakSeen) begin
      stateNxt   = ST_ARMED;
      fallIdxNxt = '0;
    end else begin
      unique case (state)
        ST_ARMED: if (fallDet) begin
          cmd.cntClear = 1'b1;
          fallIdxNxt   = '0;
          stateNxt     = ST_COUNT;
        end
        ST_COUNT: begin
          cmd.cntRun = 1'b1;
          if (rxByteValid) begin
            errSet   = 1'b1;
            stateNxt = ST_FAULT;
          end else if (fallDet) begin
            if (fallIdx == LAST_FALL) stateNxt = ST_CHECK;
            else                      fallIdxNxt = fallIdx + 1'b1;
          end
        end
        ST_CHECK: if (rxByteValid) begin
          if (measGood) begin
            cmd.divLoad = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            errSet   = 1'b1;
            stateNxt = ST_FAULT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fallIdx <= '0;
      divLoad <= 1'b0;
      synced  <= 1'b0;
      syncErr <= 1'b0;
    end else begin
      state   <= stateNxt;
      fallIdx <= fallIdxNxt;
      divLoad <= cmd.divLoad;
      if (breakSeen)        synced <= 1'b0;
      else if (cmd.divLoad) synced <= 1'b1;
      if (errSet)        syncErr <= 1'b1;
      else if (errClear) syncErr <= 1'b0;
    end
  end

  a_r5_load_sets_synced: assert property (@(posedge clk) disable iff (!rstN)
    divLoad |-> synced);

  a_r5_break_drops_synced: assert property (@(posedge clk) disable iff (!rstN)
    breakSeen |=> !synced);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (syncErr && !errClear) |=> syncErr);

  a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT && !breakSeen) |=> !divLoad);

  a_r4_load_from_check: assert property (@(posedge clk) disable iff (!rstN)
    cmd.divLoad |-> (state == ST_CHECK && rxByteValid));

endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud
  import lin_ab_pkg::*;
#(
  parameter int INT_W    = 13,
  parameter int FRAC_W   = 3,
  parameter int BIT_LOG2 = 3,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              breakSeen,
  input  logic [7:0]        rxByte,
  input  logic              rxByteValid,
  input  logic              errClear,
  output logic [INT_W-1:0]  divInt,
  output logic [FRAC_W-1:0] divFrac,
  output logic              divLoad,
  output logic              synced,
  output logic              syncErr
);

  abCmd_t cmd;
  logic fallDet, cntSat, cntZero;

  lab_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .breakSeen(breakSeen), .rxByte(rxByte),
    .rxByteValid(rxByteValid), .errClear(errClear), .fallDet(fallDet),
    .cntSat(cntSat), .cntZero(cntZero), .cmd(cmd), .divLoad(divLoad),
    .synced(synced), .syncErr(syncErr)
  );

  lab_meas #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .BIT_LOG2(BIT_LOG2), .OVS_LOG2(OVS_LOG2)
  ) uMeas (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .cmd(cmd), .fallDet(fallDet),
    .cntSat(cntSat), .cntZero(cntZero), .divInt(divInt), .divFrac(divFrac)
  );

endmodule

// File: tb/lin_autobaud_test.sv
module lin_autobaud_test;

  localparam int INT_W  = 6;
  localparam int FRAC_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic breakSeen = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic rxByteValid = 1'b0;
  logic errClear = 1'b0;
  logic [INT_W-1:0] divInt;
  logic [FRAC_W-1:0] divFrac;
  logic divLoad, synced, syncErr;

  int nChecks = 0;
  int nErrors = 0;
  bit doneRun = 0;

  always #2.5 clk = ~clk;

  lin_autobaud #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .breakSeen(breakSeen),
    .rxByte(rxByte), .rxByteValid(rxByteValid), .errClear(errClear),
    .divInt(divInt), .divFrac(divFrac), .divLoad(divLoad),
    .synced(synced), .syncErr(syncErr)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  task automatic pulseBreak();
    @(negedge clk) breakSeen = 1'b1;
    @(negedge clk) breakSeen = 1'b0;
  endtask

  // Start bit, eight data bits LSB first, stop bit; p clocks each.
  task automatic driveWave(int p, logic [7:0] wave);
    rxIn = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = wave[i];
      repeat (p) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  // Byte strobe for one cycle; returns on the negedge after the capturing edge.
  task automatic giveByte(logic [7:0] b);
    @(negedge clk);
    rxByte = b;
    rxByteValid = 1'b1;
    @(negedge clk);
    rxByteValid = 1'b0;
  endtask

  task automatic goodFrame(int p);
    int expInt, expFrac;
    pulseBreak();
    repeat (3) @(negedge clk);
    driveWave(p, 8'h55);
    giveByte(8'h55);
    expInt  = (8 * p) >> 7;
    expFrac = ((8 * p) >> 4) & 7;
    check("R4 divLoad pulse", divLoad, 1);
    check("R1 R2 divInt", divInt, expInt);
    check("R1 R2 divFrac", divFrac, expFrac);
    check("R5 synced on load", synced, 1);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!doneRun) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    int lastInt, lastFrac;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 divInt", divInt, 0);
    check("R11 divFrac", divFrac, 0);
    check("R11 divLoad", divLoad, 0);
    check("R11 synced", synced, 0);
    check("R11 syncErr", syncErr, 0);

    // R3: sync field without a break
    driveWave(20, 8'h55);
    giveByte(8'h55);
    check("R3 no load without break", divLoad, 0);
    check("R3 divInt untouched", divInt, 0);
    check("R3 synced low", synced, 0);

    // Sweep of bit periods
    for (int p = 16; p <= 200; p += 3) goodFrame(p);
    goodFrame(1000);
    @(negedge clk);
    check("R4 divLoad one cycle", divLoad, 0);
    lastInt = divInt;
    lastFrac = divFrac;

    // R5: break clears synced
    pulseBreak();
    check("R5 break clears synced", synced, 0);

    // R6: wrong sync byte
    repeat (3) @(negedge clk);
    driveWave(40, 8'h55);
    giveByte(8'h54);
    check("R6 syncErr set", syncErr, 1);
    check("R6 no load", divLoad, 0);
    check("R6 divInt kept", divInt, lastInt);
    check("R6 divFrac kept", divFrac, lastFrac);
    giveByte(8'h55);
    check("R6 later byte ignored", divLoad, 0);
    check("R6 synced stays low", synced, 0);

    // R9: clear, then error and clear in the same cycle
    @(negedge clk) errClear = 1'b1;
    @(negedge clk) errClear = 1'b0;
    check("R9 clear pulse", syncErr, 0);
    pulseBreak();
    driveWave(40, 8'h55);
    @(negedge clk);
    rxByte = 8'hAA;
    rxByteValid = 1'b1;
    errClear = 1'b1;
    @(negedge clk);
    rxByteValid = 1'b0;
    errClear = 1'b0;
    check("R9 set wins over clear", syncErr, 1);
    repeat (5) @(negedge clk);
    check("R9 sticky", syncErr, 1);
    @(negedge clk) errClear = 1'b1;
    @(negedge clk) errClear = 1'b0;

    // R7: byte before measurement completes
    pulseBreak();
    driveWave(30, 8'h00);
    giveByte(8'h55);
    check("R7 early byte error", syncErr, 1);
    check("R7 no load", divLoad, 0);
    check("R7 divInt kept", divInt, lastInt);
    @(negedge clk) errClear = 1'b1;
    @(negedge clk) errClear = 1'b0;

    // R8: saturated measurement (13-bit counter, 8*1100 exceeds it)
    pulseBreak();
    driveWave(1100, 8'h55);
    giveByte(8'h55);
    check("R8 saturation error", syncErr, 1);
    check("R8 no load", divLoad, 0);
    check("R8 divInt kept", divInt, lastInt);
    @(negedge clk) errClear = 1'b1;
    @(negedge clk) errClear = 1'b0;

    // R10: break in mid measurement, then a full field at p=72
    pulseBreak();
    rxIn = 1'b0;
    repeat (50) @(negedge clk);
    rxIn = 1'b1;
    repeat (50) @(negedge clk);
    rxIn = 1'b0;
    repeat (50) @(negedge clk);
    rxIn = 1'b1;
    repeat (50) @(negedge clk);
    pulseBreak();
    driveWave(72, 8'h55);
    giveByte(8'h55);
    check("R10 restart load", divLoad, 1);
    check("R10 divInt", divInt, 4);
    check("R10 divFrac", divFrac, 4);
    lastInt = divInt;

    // R10: break and sync byte in the same cycle
    pulseBreak();
    driveWave(48, 8'h55);
    @(negedge clk);
    rxByte = 8'h55;
    rxByteValid = 1'b1;
    breakSeen = 1'b1;
    @(negedge clk);
    rxByteValid = 1'b0;
    breakSeen = 1'b0;
    check("R10 break beats byte load", divLoad, 0);
    check("R10 break beats byte synced", synced, 0);
    check("R10 divInt kept", divInt, lastInt);
    check("R6 no error from re-arm", syncErr, 0);

    doneRun = 1;
    finishRun();
  end

endmodule